// File: doc/BRIEF.md
# Serial-In Transparent-Latch Output Driver

This block turns a slow external serial stream into eight channel drive signals. A serial data bit is shifted into an eight-stage register on each rising edge of an external shift clock. A level-sensitive latch bank copies the register while a strobe is high and holds it once the strobe drops. The latched pattern reaches the channel outputs through an output-disable gate and a per-channel force-off mask. The last register stage appears on a serial output, so several copies can be daisy-chained.

The external shift clock, data, clear, strobe and disable pins are asynchronous to the block. The block runs on a fast system clock and passes each of them through a two-flop synchronizer. The shift clock's rising edge is found by comparing its synchronized level with its value one system cycle earlier. Clear has no effect until clocked: while it is high, each shift edge loads a zero in place of the serial bit. The force-off inputs come from a fault block in the same clock domain and act on the next system clock edge.

Top module: `serial_latch_driver`

## Requirements
- R1: During and after a synchronous reset, all channel outputs are 0 and the serial output is 0. The shift register and latches hold all zeros.
- R2: On each rising edge of the synchronized shift clock, stage 0 takes the serial input and every stage k takes stage k-1. After eight edges, the first bit shifted in sits at index 7. No other event, including a falling edge, changes the register.
- R3: The serial output always shows the highest stage (index 7) of the shift register.
- R4: While clear is high, each shift edge loads 0 into stage 0 whatever the serial input is. Clear changes neither the latches nor the outputs until a strobe follows.
- R5: While strobe is high, the latches follow the shift register, and a shift made during the strobe reaches the outputs. While strobe is low, the latches keep their value even when the register shifts.
- R6: While the output-disable input is high, all channel outputs are 0. The latch and shift-register contents are kept, so the pattern returns when disable goes low and the serial output is unaffected.
- R7: While output-disable is low, channel output i equals latch bit i (1 = channel on). Channel output bit i is driven by latch bit i, which receives register stage i.
- R8: A high force-off bit i turns channel output i off on the following system clock edge and leaves the other channels untouched.
- R9: A shift clock held high for many system cycles produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit, asynchronous |
| shift_clk | input | 1 | External shift clock, rising edge active, asynchronous |
| clear | input | 1 | When high, shift edges load 0 |
| strobe | input | 1 | Latch follow enable, level sensitive |
| outputs_off | input | 1 | High forces every channel output off |
| force_off | input | NUM_CH | Per-channel off override from a fault block |
| ch_on | output | NUM_CH | Registered channel drive, 1 = channel sinks current |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
The hardest case to reach from the ports is a shift made while the latches are transparent. The bench must show that such a shift reaches the outputs, and that the same kind of shift after the strobe falls does not. The stimulus raises the strobe and holds it. It then pulses the shift clock twice and checks each intermediate pattern on the outputs. It drops the strobe, shifts once more, and confirms both that the outputs stay put and that the serial output moved. A shift clock held high for many system cycles is also driven, to show that one long pulse yields a single shift.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // Index of each external control in the synchronizer bank
  localparam int CTL_SER    = 0;
  localparam int CTL_SCLK   = 1;
  localparam int CTL_CLR    = 2;
  localparam int CTL_STB    = 3;
  localparam int CTL_OFF    = 4;
  localparam int CTL_COUNT  = 5;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sld_shift_path.sv
module sld_shift_path #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_lvl,
  input  logic              clr_lvl,
  input  logic              din,
  output logic [NUM_CH-1:0] stages
);
  logic sclk_prev;
  logic rise;

  assign rise = sclk_lvl & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      stages    <= '0;
    end else begin
      sclk_prev <= sclk_lvl;
      if (rise) stages <= {stages[NUM_CH-2:0], (clr_lvl ? 1'b0 : din)};
    end
  end
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              follow,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (follow) q <= din;
  end
endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              all_off,
  input  logic [NUM_CH-1:0] lat,
  input  logic [NUM_CH-1:0] force_off,
  output logic [NUM_CH-1:0] ch_on
);
  always_ff @(posedge clk) begin
    if (rst)          ch_on <= '0;
    else if (all_off) ch_on <= '0;
    else              ch_on <= lat & ~force_off;
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              shift_clk,
  input  logic              clear,
  input  logic              strobe,
  input  logic              outputs_off,
  input  logic [NUM_CH-1:0] force_off,
  output logic [NUM_CH-1:0] ch_on,
  output logic              ser_out
);
  logic [CTL_COUNT-1:0] ctl_raw;
  logic [CTL_COUNT-1:0] ctl_s;
  logic [NUM_CH-1:0]    sr_q;
  logic [NUM_CH-1:0]    lat_q;

  assign ctl_raw[CTL_SER]  = ser_in;
  assign ctl_raw[CTL_SCLK] = shift_clk;
  assign ctl_raw[CTL_CLR]  = clear;
  assign ctl_raw[CTL_STB]  = strobe;
  assign ctl_raw[CTL_OFF]  = outputs_off;

  // Every pin gets the same depth, so data and clock stay aligned
  for (genvar g = 0; g < CTL_COUNT; g++) begin : g_sync
    sld_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   (ctl_raw[g]),
      .q   (ctl_s[g])
    );
  end

  sld_shift_path #(.NUM_CH(NUM_CH)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .sclk_lvl (ctl_s[CTL_SCLK]),
    .clr_lvl  (ctl_s[CTL_CLR]),
    .din      (ctl_s[CTL_SER]),
    .stages   (sr_q)
  );

  sld_latch_bank #(.NUM_CH(NUM_CH)) latch_i (
    .clk    (clk),
    .rst    (rst),
    .follow (ctl_s[CTL_STB]),
    .din    (sr_q),
    .q      (lat_q)
  );

  sld_out_gate #(.NUM_CH(NUM_CH)) gate_i (
    .clk       (clk),
    .rst       (rst),
    .all_off   (ctl_s[CTL_OFF]),
    .lat       (lat_q),
    .force_off (force_off),
    .ch_on     (ch_on)
  );

  assign ser_out = sr_q[NUM_CH-1];
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk_s,
  input logic              clr_s,
  input logic              stb_s,
  input logic              off_s,
  input logic [NUM_CH-1:0] force_off,
  input logic [NUM_CH-1:0] sr_q,
  input logic [NUM_CH-1:0] lat_q,
  input logic [NUM_CH-1:0] ch_on
);
  logic sclk_d;
  logic rst_d;
  logic edge_seen;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign edge_seen = sclk_s & ~sclk_d;

  // R1: the cycle after a reset cycle leaves all outputs off
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_off_R1: assert (ch_on == '0 && sr_q == '0 && lat_q == '0);
    end
  end

  assert_no_edge_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !edge_seen |=> $stable(sr_q));

  assert_shift_move_R2: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> sr_q[NUM_CH-1:1] == $past(sr_q[NUM_CH-2:0]));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (edge_seen && clr_s) |=> !sr_q[0]);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> $stable(lat_q));

  assert_disable_off_R6: assert property (@(posedge clk) disable iff (rst)
    off_s |=> ch_on == '0);

  assert_force_off_R8: assert property (@(posedge clk) disable iff (rst)
    (|force_off) |=> (ch_on & $past(force_off)) == '0);
endmodule

bind serial_latch_driver sld_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .sclk_s    (ctl_s[sld_pkg::CTL_SCLK]),
  .clr_s     (ctl_s[sld_pkg::CTL_CLR]),
  .stb_s     (ctl_s[sld_pkg::CTL_STB]),
  .off_s     (ctl_s[sld_pkg::CTL_OFF]),
  .force_off (force_off),
  .sr_q      (sr_q),
  .lat_q     (lat_q),
  .ch_on     (ch_on)
);

// File: tb/serial_latch_driver_tb_top.sv
`timescale 1ns/1ps
module serial_latch_driver_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic         shift_clk = 1'b0;
  logic         clear = 1'b0;
  logic         strobe = 1'b0;
  logic         outputs_off = 1'b0;
  logic [N-1:0] force_off = '0;
  logic [N-1:0] ch_on;
  logic         ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_latch_driver #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
    .clear(clear), .strobe(strobe), .outputs_off(outputs_off),
    .force_off(force_off), .ch_on(ch_on), .ser_out(ser_out)
  );

  // pattern, clear, disable, force mask, expected outputs, expected serial out
  typedef struct packed {
    logic [7:0] pat;
    logic       clr;
    logic       off;
    logic [7:0] frc;
    logic [7:0] exp_on;
    logic       exp_so;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'hA5, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1},
    '{8'h3C, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0},
    '{8'hFF, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1},
    '{8'h81, 1'b0, 1'b0, 8'h01, 8'h80, 1'b1},
    '{8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    '{8'hFF, 1'b0, 1'b0, 8'hF0, 8'h0F, 1'b1},
    '{8'h01, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    cyc(4);
    shift_clk = 1'b1;
    cyc(4);
    shift_clk = 1'b0;
    cyc(4);
  endtask

  task automatic load(input logic [7:0] pat);
    for (int i = 7; i >= 0; i--) shift_bit(pat[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    cyc(6);
    strobe = 1'b0;
    cyc(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(5);
    check("R1 outputs in reset", ch_on, '0);
    rst = 1'b0;
    cyc(3);
    check("R1 outputs after reset", ch_on, '0);
    check("R1 serial out after reset", {7'd0, ser_out}, 8'h00);

    // R2 R3 R4 R6 R7 R8: table walk
    foreach (VECS[k]) begin
      clear = VECS[k].clr;
      load(VECS[k].pat);
      clear = 1'b0;
      pulse_strobe();
      outputs_off = VECS[k].off;
      force_off = VECS[k].frc;
      cyc(6);
      check("R2/R7 table outputs", ch_on, VECS[k].exp_on);
      check("R3 table serial out", {7'd0, ser_out}, {7'd0, VECS[k].exp_so});
      outputs_off = 1'b0;
      force_off = '0;
      cyc(4);
    end

    // R4: clear alone does not reach the outputs before a strobe
    load(8'hE7);
    pulse_strobe();
    clear = 1'b1;
    load(8'hFF);
    clear = 1'b0;
    check("R4 clear without strobe", ch_on, 8'hE7);
    pulse_strobe();
    check("R4 cleared after strobe", ch_on, 8'h00);

    // R5: hold while strobe low
    load(8'hC3);
    pulse_strobe();
    load(8'h18);
    check("R5 hold with strobe low", ch_on, 8'hC3);
    pulse_strobe();
    check("R5 new pattern after strobe", ch_on, 8'h18);

    // R5: transparent while strobe high
    strobe = 1'b1;
    cyc(6);
    shift_bit(1'b1);
    check("R5 transparent shift 1", ch_on, 8'h31);
    shift_bit(1'b0);
    check("R5 transparent shift 2", ch_on, 8'h62);
    strobe = 1'b0;
    cyc(6);
    shift_bit(1'b1);
    check("R5 held after strobe falls", ch_on, 8'h62);
    check("R3 serial out moved", {7'd0, ser_out}, 8'h01);

    // R6: disable keeps contents
    outputs_off = 1'b1;
    cyc(6);
    check("R6 disabled outputs", ch_on, 8'h00);
    check("R6 serial out kept", {7'd0, ser_out}, 8'h01);
    outputs_off = 1'b0;
    cyc(6);
    check("R6 pattern returns", ch_on, 8'h62);

    // R9: long shift clock pulse shifts once (register holds C5)
    ser_in = 1'b0;
    cyc(4);
    shift_clk = 1'b1;
    cyc(30);
    shift_clk = 1'b0;
    cyc(4);
    pulse_strobe();
    check("R9 single shift from long pulse", ch_on, 8'h8A);

    // R8: one channel forced off
    force_off = 8'h02;
    cyc(2);
    check("R8 single channel forced", ch_on, 8'h88);
    force_off = '0;
    cyc(2);
    check("R8 release", ch_on, 8'h8A);

    // R3: cascade bit
    load(8'h80);
    check("R3 serial out first bit", {7'd0, ser_out}, 8'h01);
    shift_bit(1'b0);
    check("R3 serial out after extra shift", {7'd0, ser_out}, 8'h00);

    // R1: reset mid-run
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(2);
    check("R1 reset clears outputs", ch_on, 8'h00);
    pulse_strobe();
    check("R1 latches cleared", ch_on, 8'h00);

    finish_run();
  end
endmodule